// File: doc/BRIEF.md
# Encoder Position Capture and Unit Timer

This block sits beside a quadrature position counter and takes snapshots of the counter's live value. It has two capture registers. The hold register is loaded from a self-clearing hold-request bit or from a unit-timer match. Software can set the request bit, and so can a rising edge on any of four external timer event flags whose source enable is on. The latch register is loaded on each index edge while index latching is enabled.

A free-running unit timer counts system clocks up to a programmable compare value. On a match the timer wraps to zero and raises a sticky event flag. Depending on its enables, the same match also captures the position into the hold register and sends a one-cycle reset request to the position counter. An index reset event can restart the unit timer. Software can load the timer's counter, but only while the timer is stopped.

The captured values are level outputs that hold until the next capture. They are not streamed, so the block has no handshake. All control and status pins are plain levels or one-cycle pulses.

Top module: `enc_capture_unit`

## Requirements
- R1: One clock edge after `sw_hold_set` is high while `hold_req` is low, `hold_req` reads 1. At the next edge `hold_val` takes the `pos_count` value present at that edge, and `hold_req` returns to 0.
- R2: Bit i of `hold_src_en` lets a 0-to-1 change of `tmr_flag[i]` set `hold_req` at the next edge. A flag whose enable is 0, or a flag that stays high, causes no capture.
- R3: If a software set and an enabled timer-flag rise occur in the same cycle, `hold_req` is high for exactly one cycle and only one capture is made.
- R4: With `idx_latch_en` high, a cycle with `index_edge` high loads `pos_count` into `latch_val` at that edge. With `idx_latch_en` low, `latch_val` does not change.
- R5: While `ut_en` is 1, `ut_count` rises by one per clock. In a cycle where it equals `ut_cmp`, the next edge returns it to 0, so one period is `ut_cmp`+1 clocks.
- R6: A unit-timer match sets `ut_event`. It stays set until a cycle with `ut_flag_clr` high, and a match in that same cycle wins over the clear.
- R7: With `ut_hold_en` high, a unit-timer match loads `pos_count` into `hold_val` at the match edge. With it low, the match leaves `hold_val` alone.
- R8: With `ut_rst_pos_en` high, a unit-timer match drives `pos_rst_req` high for exactly the one cycle after the match edge. With it low, `pos_rst_req` stays 0.
- R9: When `index_edge` is high with both `idx_rst_ut_sel` and `idx_reload_en` set, `ut_count` is 0 after that edge. If either select is low, the count continues.
- R10: `ut_wr` loads `ut_wdata` into `ut_count` only while `ut_en` is 0. While the timer is enabled, the write is ignored.
- R11: After reset, `hold_val`, `latch_val`, `ut_count`, `ut_event`, `pos_rst_req` and `hold_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_count | input | 32 | Live position counter value |
| index_edge | input | 1 | One-cycle pulse marking an index rising edge |
| tmr_flag | input | 4 | External timer event flags (levels) |
| hold_src_en | input | 4 | Per-flag enable for hold triggering |
| sw_hold_set | input | 1 | Software write of 1 to the hold-request bit |
| idx_latch_en | input | 1 | Enable latching on index edges |
| idx_reload_en | input | 1 | Index reload of the position counter enabled |
| idx_rst_ut_sel | input | 1 | Index reset event also restarts the unit timer |
| ut_en | input | 1 | Unit timer run enable |
| ut_hold_en | input | 1 | Unit-timer match captures into the hold register |
| ut_rst_pos_en | input | 1 | Unit-timer match requests a position reset |
| ut_cmp | input | 32 | Unit timer compare value |
| ut_wr | input | 1 | Software write strobe for the unit timer counter |
| ut_wdata | input | 32 | Data for the unit timer counter write |
| ut_flag_clr | input | 1 | Write-1 clear of the unit-timer event flag |
| hold_val | output | 32 | Hold capture register |
| latch_val | output | 32 | Index latch register |
| hold_req | output | 1 | Hold-request bit (self-clearing) |
| ut_count | output | 32 | Unit timer counter |
| ut_event | output | 1 | Sticky unit-timer event flag |
| pos_rst_req | output | 1 | One-cycle position counter reset request |

## Verification
A software or timer hold request shows up on `hold_req` one edge after the stimulus, and the hold register updates on the edge after that. Index latching and index restart of the timer take effect on the same edge that sees `index_edge`. A unit-timer match updates the count, the event flag, the position-reset pulse and the hold capture all on the match edge, so each is visible one edge after the cycle in which the count equals the compare value. The bench drives every input on the falling clock edge and counts rising edges before each check, which it takes on the following falling edge. Where a capture must sample the live count on one exact edge, the bench changes `pos_count` between the request edge and the capture edge.

// File: rtl/enc_cap_pkg.sv
package enc_cap_pkg;
  // Unit timer controls, grouped for the path from top to timer.
  typedef struct packed {
    logic run;        // timer counting
    logic cap_hold;   // match captures the position
    logic rst_pos;    // match requests a position reset
    logic idx_clear;  // index reset event restarts the timer
  } ut_cfg_t;
endpackage

// File: rtl/enc_hold_ctrl.sv
module enc_hold_ctrl #(
  parameter int unsigned CW     = 32,
  parameter int unsigned N_TMR  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    pos_count,
  input  logic [N_TMR-1:0] tmr_flag,
  input  logic [N_TMR-1:0] src_en,
  input  logic             sw_set,
  input  logic             ut_cap,
  output logic             req,
  output logic [CW-1:0]    hold_q
);
  logic [N_TMR-1:0] flag_d;
  logic [N_TMR-1:0] flag_rise;
  logic             set_any;

  // Edge detector per external timer flag
  for (genvar g = 0; g < N_TMR; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_d[g] <= 1'b0;
      else        flag_d[g] <= tmr_flag[g];
    end
    assign flag_rise[g] = tmr_flag[g] & ~flag_d[g] & src_en[g];
  end

  // Software and flag sources merge into one set, so at most one capture
  assign set_any = sw_set | (|flag_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       req <= 1'b0;
    else if (req)     req <= 1'b0;
    else if (set_any) req <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_q <= '0;
    else if (req || ut_cap)  hold_q <= pos_count;
  end

  p_req_selfclear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  p_req_copy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (hold_q == $past(pos_count)));
  p_sw_sets_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set && !req) |=> req);
endmodule

// File: rtl/enc_unit_timer.sv
module enc_unit_timer
  import enc_cap_pkg::*;
#(
  parameter int unsigned TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ut_cfg_t       cfg,
  input  logic          idx_edge,
  input  logic          idx_reload_en,
  input  logic [TW-1:0] cmp,
  input  logic          wr,
  input  logic [TW-1:0] wdata,
  input  logic          flag_clr,
  output logic [TW-1:0] cnt,
  output logic          evt,
  output logic          pos_rst,
  output logic          match
);
  logic idx_restart;

  assign match       = cfg.run && (cnt == cmp);
  assign idx_restart = cfg.idx_clear && idx_reload_en && idx_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (idx_restart) cnt <= '0;
    else if (cfg.run)     cnt <= match ? '0 : cnt + 1'b1;
    else if (wr)          cnt <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        evt <= 1'b0;
    else if (match)    evt <= 1'b1;
    else if (flag_clr) evt <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_rst <= 1'b0;
    else        pos_rst <= match && cfg.rst_pos;
  end

  p_wrap_on_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.run && cnt == cmp) |=> (cnt == '0));
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.run && cnt != cmp && !idx_edge) |=> (cnt == $past(cnt) + 1'b1));
  p_evt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !flag_clr) |=> evt);
  p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pos_rst |=> !pos_rst || $past(match));
  p_idx_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_edge && cfg.idx_clear && idx_reload_en) |=> (cnt == '0));
  p_write_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.run && !idx_edge && wr) |=> (cnt == $past(wdata)));
endmodule

// File: rtl/enc_capture_unit.sv
module enc_capture_unit
  import enc_cap_pkg::*;
#(
  parameter int unsigned CW    = 32,
  parameter int unsigned N_TMR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    pos_count,
  input  logic             index_edge,
  input  logic [N_TMR-1:0] tmr_flag,
  input  logic [N_TMR-1:0] hold_src_en,
  input  logic             sw_hold_set,
  input  logic             idx_latch_en,
  input  logic             idx_reload_en,
  input  logic             idx_rst_ut_sel,
  input  logic             ut_en,
  input  logic             ut_hold_en,
  input  logic             ut_rst_pos_en,
  input  logic [CW-1:0]    ut_cmp,
  input  logic             ut_wr,
  input  logic [CW-1:0]    ut_wdata,
  input  logic             ut_flag_clr,
  output logic [CW-1:0]    hold_val,
  output logic [CW-1:0]    latch_val,
  output logic             hold_req,
  output logic [CW-1:0]    ut_count,
  output logic             ut_event,
  output logic             pos_rst_req
);
  ut_cfg_t ucfg;
  logic    ut_match;

  assign ucfg.run       = ut_en;
  assign ucfg.cap_hold  = ut_hold_en;
  assign ucfg.rst_pos   = ut_rst_pos_en;
  assign ucfg.idx_clear = idx_rst_ut_sel;

  enc_unit_timer #(.TW(CW)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg          (ucfg),
    .idx_edge     (index_edge),
    .idx_reload_en(idx_reload_en),
    .cmp          (ut_cmp),
    .wr           (ut_wr),
    .wdata        (ut_wdata),
    .flag_clr     (ut_flag_clr),
    .cnt          (ut_count),
    .evt          (ut_event),
    .pos_rst      (pos_rst_req),
    .match        (ut_match)
  );

  enc_hold_ctrl #(.CW(CW), .N_TMR(N_TMR)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .pos_count(pos_count),
    .tmr_flag (tmr_flag),
    .src_en   (hold_src_en),
    .sw_set   (sw_hold_set),
    .ut_cap   (ut_match && ucfg.cap_hold),
    .req      (hold_req),
    .hold_q   (hold_val)
  );

  // Index latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           latch_val <= '0;
    else if (idx_latch_en && index_edge)  latch_val <= pos_count;
  end

  p_latch_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_latch_en && index_edge) |=> (latch_val == $past(pos_count)));
  p_latch_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(idx_latch_en && index_edge) |=> $stable(latch_val));
  p_ut_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ut_en && ut_hold_en && ut_count == ut_cmp) |=> (hold_val == $past(pos_count)));
endmodule

// File: tb/enc_capture_unit_tb_top.sv
module enc_capture_unit_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pos_count = '0;
  logic        index_edge = 1'b0;
  logic [3:0]  tmr_flag = '0;
  logic [3:0]  hold_src_en = '0;
  logic        sw_hold_set = 1'b0;
  logic        idx_latch_en = 1'b0;
  logic        idx_reload_en = 1'b0;
  logic        idx_rst_ut_sel = 1'b0;
  logic        ut_en = 1'b0;
  logic        ut_hold_en = 1'b0;
  logic        ut_rst_pos_en = 1'b0;
  logic [31:0] ut_cmp = '0;
  logic        ut_wr = 1'b0;
  logic [31:0] ut_wdata = '0;
  logic        ut_flag_clr = 1'b0;
  logic [31:0] hold_val, latch_val, ut_count;
  logic        hold_req, ut_event, pos_rst_req;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  enc_capture_unit dut_i (
    .clk(clk), .rst_n(rst_n), .pos_count(pos_count), .index_edge(index_edge),
    .tmr_flag(tmr_flag), .hold_src_en(hold_src_en), .sw_hold_set(sw_hold_set),
    .idx_latch_en(idx_latch_en), .idx_reload_en(idx_reload_en),
    .idx_rst_ut_sel(idx_rst_ut_sel), .ut_en(ut_en), .ut_hold_en(ut_hold_en),
    .ut_rst_pos_en(ut_rst_pos_en), .ut_cmp(ut_cmp), .ut_wr(ut_wr),
    .ut_wdata(ut_wdata), .ut_flag_clr(ut_flag_clr), .hold_val(hold_val),
    .latch_val(latch_val), .hold_req(hold_req), .ut_count(ut_count),
    .ut_event(ut_event), .pos_rst_req(pos_rst_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Advance one rising edge, land on the following falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 hold_val", hold_val, 0);
    check("R11 latch_val", latch_val, 0);
    check("R11 ut_count", ut_count, 0);
    check("R11 ut_event", {31'd0, ut_event}, 0);
    check("R11 pos_rst_req", {31'd0, pos_rst_req}, 0);
    check("R11 hold_req", {31'd0, hold_req}, 0);
  endtask

  task automatic t_sw_hold();
    pos_count = 32'h1234;
    sw_hold_set = 1'b1;
    step();
    sw_hold_set = 1'b0;
    check("R1 req raised", {31'd0, hold_req}, 1);
    check("R1 no early copy", hold_val, 0);
    pos_count = 32'hABCD;
    step();
    check("R1 copy at capture edge", hold_val, 32'hABCD);
    check("R1 req self-clears", {31'd0, hold_req}, 0);
  endtask

  task automatic t_tmr_hold();
    hold_src_en = 4'b0100;
    pos_count = 32'd77;
    tmr_flag[2] = 1'b1;
    step();
    step();
    check("R2 enabled flag captures", hold_val, 32'd77);
    pos_count = 32'd88;
    tmr_flag[0] = 1'b1;
    repeat (3) step();
    check("R2 disabled flag and held flag ignored", hold_val, 32'd77);
    check("R2 no request pending", {31'd0, hold_req}, 0);
    tmr_flag = '0;
    step();
  endtask

  task automatic t_same_cycle();
    hold_src_en = 4'b0010;
    pos_count = 32'h42;
    sw_hold_set = 1'b1;
    tmr_flag[1] = 1'b1;
    step();
    sw_hold_set = 1'b0;
    check("R3 req high once", {31'd0, hold_req}, 1);
    step();
    check("R3 req low after one cycle", {31'd0, hold_req}, 0);
    check("R3 captured", hold_val, 32'h42);
    pos_count = 32'h43;
    step();
    check("R3 no second capture", hold_val, 32'h42);
    tmr_flag = '0;
    hold_src_en = '0;
    step();
  endtask

  task automatic t_latch();
    idx_latch_en = 1'b0;
    pos_count = 32'h10;
    index_edge = 1'b1;
    step();
    index_edge = 1'b0;
    check("R4 latch disabled", latch_val, 0);
    idx_latch_en = 1'b1;
    pos_count = 32'h20;
    index_edge = 1'b1;
    step();
    index_edge = 1'b0;
    check("R4 latch on index", latch_val, 32'h20);
  endtask

  task automatic t_ut_count();
    ut_cmp = 32'd3;
    ut_hold_en = 1'b1;
    ut_rst_pos_en = 1'b1;
    pos_count = 32'h99;
    ut_en = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      step();
      check("R5 increment", ut_count, k);
    end
    check("R6 no flag before match", {31'd0, ut_event}, 0);
    step();
    check("R5 wrap to zero", ut_count, 0);
    check("R6 flag set", {31'd0, ut_event}, 1);
    check("R8 reset pulse", {31'd0, pos_rst_req}, 1);
    check("R7 match captures", hold_val, 32'h99);
    step();
    check("R5 count after wrap", ut_count, 1);
    check("R8 pulse one cycle", {31'd0, pos_rst_req}, 0);
    check("R6 flag sticky", {31'd0, ut_event}, 1);
    ut_flag_clr = 1'b1;
    step();
    ut_flag_clr = 1'b0;
    check("R6 flag cleared", {31'd0, ut_event}, 0);
    ut_en = 1'b0;
    step();
  endtask

  task automatic t_ut_wr();
    ut_wdata = 32'd50;
    ut_wr = 1'b1;
    step();
    ut_wr = 1'b0;
    check("R10 write while stopped", ut_count, 32'd50);
    ut_cmp = 32'd1000;
    ut_en = 1'b1;
    step();
    check("R10 counting", ut_count, 32'd51);
    ut_wdata = 32'd7;
    ut_wr = 1'b1;
    step();
    ut_wr = 1'b0;
    check("R10 write ignored while running", ut_count, 32'd52);
    ut_en = 1'b0;
    ut_cmp = 32'd54;
    ut_hold_en = 1'b0;
    ut_rst_pos_en = 1'b0;
    pos_count = 32'h1111;
    step();
    check("R5 stopped holds", ut_count, 32'd52);
    ut_en = 1'b1;
    step();
    step();
    check("R8 no pulse before match", {31'd0, pos_rst_req}, 0);
    step();
    check("R5 wrap at new compare", ut_count, 0);
    check("R8 no pulse when disabled", {31'd0, pos_rst_req}, 0);
    check("R7 no capture when disabled", hold_val, 32'h99);
    check("R6 flag set again", {31'd0, ut_event}, 1);
  endtask

  task automatic t_idx_ut();
    ut_cmp = 32'd1000;
    repeat (5) step();
    check("R9 pre-count", ut_count, 32'd5);
    idx_rst_ut_sel = 1'b1;
    idx_reload_en = 1'b0;
    index_edge = 1'b1;
    step();
    index_edge = 1'b0;
    check("R9 no restart without reload", ut_count, 32'd6);
    idx_reload_en = 1'b1;
    index_edge = 1'b1;
    step();
    index_edge = 1'b0;
    check("R9 index restarts timer", ut_count, 0);
    ut_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_sw_hold();
    t_tmr_hold();
    t_same_cycle();
    t_latch();
    t_ut_count();
    t_ut_wr();
    t_idx_ut();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule